// File: doc/BRIEF.md
# Disk Sector Byte-Address Generator

This block turns the task-file register values of a disk command into the byte offset where the transfer starts. A mode bit in the drive/head register chooses between a flat block number, built from four register fields, and a cylinder/head/sector triple. The triple is converted to a block number using the drive geometry: the head count and the sectors-per-track count. The block number is then scaled by the sector size. If the sector size input is zero, 512 bytes is used.

The computation is multi-cycle and works as a start/done handshake. A `start` pulse accepted while idle captures all inputs. Exactly three clock edges later `done` pulses for one cycle, together with either a valid byte address or an error flag. After a good result, each `advance` pulse moves the address on by one sector. The transfer engine uses this to step through a multi-sector command without starting the block again.

Top module: `sector_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `valid` and `err` are 0 and `byte_addr` is 0.
- R2: When bit 6 of `drv_head` is 1, the block number is {`drv_head`[3:0], `cyl_hi`, `cyl_lo`, `sect_num`} (a 28-bit value, `sect_num` in the low byte).
- R3: When bit 6 of `drv_head` is 0, the block number is (cyl × `geo_heads` + head) × `geo_spt` + `sect_num` − 1. Here cyl = {`cyl_hi`, `cyl_lo`} and head = `drv_head`[3:0].
- R4: `byte_addr` = block number × sector size, kept modulo 2^40.
- R5: A `sect_bytes` value of 0 means a sector size of 512.
- R6: In cylinder/head/sector mode, a `geo_heads` or `geo_spt` of 0 gives `err`=1, `valid`=0 and `byte_addr`=0 in the `done` cycle.
- R7: In cylinder/head/sector mode, a `sect_num` of 0 is rejected the same way, because sector numbering starts at 1.
- R8: `done` is high for exactly one cycle, in the cycle after the third rising edge that follows the edge accepting `start`. `valid` and `err` are already correct in that cycle.
- R9: While idle and not starting, an `advance` pulse with `valid`=1 adds the captured sector size to `byte_addr`. With `valid`=0, the pulse changes nothing.
- R10: `busy` is high from the edge that accepts `start` until the `done` cycle. A `start` or `advance` pulse that arrives while busy has no effect on the result.
- R11: In block mode the geometry inputs are ignored: a zero geometry does not cause an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| advance | input | 1 | One sector finished; step the address |
| drv_head | input | 8 | Drive/head register; bit 6 selects block mode, bits 3:0 give head or top block bits |
| cyl_hi | input | 8 | Cylinder high register |
| cyl_lo | input | 8 | Cylinder low register |
| sect_num | input | 8 | Sector number register |
| geo_heads | input | 8 | Heads per cylinder |
| geo_spt | input | 8 | Sectors per track |
| sect_bytes | input | 14 | Sector size in bytes, 0 = 512 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | `byte_addr` holds a good address |
| err | output | 1 | Last computation was rejected |
| byte_addr | output | 40 | Byte offset of the current sector |

## Verification
Suppose a captured operand or pipeline stage held a wrong value. It would surface at the `done` cycle, three edges after `start`, as a `byte_addr` different from the independently computed product. A wrong sector size would appear one cycle after the first `advance`. A wrong sequencer state would show at once as `busy` or `done` out of step with the cycle-by-cycle reference, or as a start taken while busy. Such a start would change the delivered address.

// File: rtl/sag_pkg.sv
// Package: shared constants and the sequencer state type of the
// sector address generator. Assumes 8-bit task-file registers.
package sag_pkg;
    localparam int MODE_BIT = 6;   // drive/head bit selecting block mode
    localparam int HEAD_W   = 4;   // head field / top block bits

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL1 = 2'd1,
        ST_MUL2 = 2'd2,
        ST_MUL3 = 2'd3
    } sag_state_t;
endpackage

// File: rtl/sag_field_decode.sv
// Module: splits the task-file registers into mode, flat block number,
// cylinder and head, and flags register contents that cylinder/head/sector
// mode cannot use. Purely combinational; assumes inputs are stable
// when sampled by the caller.
module sag_field_decode
    import sag_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic [REG_W-1:0]              drv_head,
    input  logic [REG_W-1:0]              cyl_hi,
    input  logic [REG_W-1:0]              cyl_lo,
    input  logic [REG_W-1:0]              sect_num,
    input  logic [REG_W-1:0]              geo_heads,
    input  logic [REG_W-1:0]              geo_spt,
    output logic                          blk_mode,
    output logic [HEAD_W+3*REG_W-1:0]     flat_blk,
    output logic [2*REG_W-1:0]            cyl,
    output logic [HEAD_W-1:0]             head,
    output logic                          bad_req
);
    // Field extraction and rejection of unusable geometry or sector zero
    always_comb begin
        blk_mode = drv_head[MODE_BIT];
        head     = drv_head[HEAD_W-1:0];
        cyl      = {cyl_hi, cyl_lo};
        flat_blk = {drv_head[HEAD_W-1:0], cyl_hi, cyl_lo, sect_num};
        bad_req  = !blk_mode &&
                   ((geo_heads == '0) || (geo_spt == '0) || (sect_num == '0));
    end
endmodule

// File: rtl/sag_muladd.sv
// Module: combinational y = a * b + c, with the result sized to YW.
// A narrower YW keeps the low bits (modulo 2^YW). Assumes AW+BW is
// within the tool's multiplier limit.
module sag_muladd #(
    parameter int AW = 8,
    parameter int BW = 8,
    parameter int CW = 8,
    parameter int YW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic [CW-1:0] c,
    output logic [YW-1:0] y
);
    localparam int PW = AW + BW;

    logic [PW-1:0] prod;

    // Full-width product, then resize and add the offset
    always_comb begin
        prod = PW'(a) * PW'(b);
        y    = YW'(prod) + YW'(c);
    end
endmodule

// File: rtl/sector_addr_gen.sv
// Module: top of the sector byte-address generator. A start pulse
// accepted while idle captures the task-file and geometry inputs. Three
// pipeline edges then form (cyl*heads+head), the block number and the
// byte address. A one-cycle done pulse carries valid or err. While
// idle with a good result, advance steps the address by one captured
// sector size. Assumes DEF_SECT fits in SZ_W bits.
module sector_addr_gen
    import sag_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int SZ_W     = 14,
    parameter int ADDR_W   = 40,
    parameter int DEF_SECT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [REG_W-1:0]  drv_head,
    input  logic [REG_W-1:0]  cyl_hi,
    input  logic [REG_W-1:0]  cyl_lo,
    input  logic [REG_W-1:0]  sect_num,
    input  logic [REG_W-1:0]  geo_heads,
    input  logic [REG_W-1:0]  geo_spt,
    input  logic [SZ_W-1:0]   sect_bytes,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic              err,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam int CYL_W  = 2 * REG_W;
    localparam int FLAT_W = HEAD_W + 3 * REG_W;
    localparam int PART_W = CYL_W + REG_W;
    localparam int BLK_W  = PART_W + REG_W;

    sag_state_t        st;
    logic              accept;

    logic              d_mode, d_bad;
    logic [FLAT_W-1:0] d_flat;
    logic [CYL_W-1:0]  d_cyl;
    logic [HEAD_W-1:0] d_head;
    logic [SZ_W-1:0]   size_eff;

    logic              r_mode, r_bad;
    logic [FLAT_W-1:0] r_flat;
    logic [CYL_W-1:0]  r_cyl;
    logic [HEAD_W-1:0] r_head;
    logic [REG_W-1:0]  r_heads, r_spt, r_sect;
    logic [SZ_W-1:0]   r_size;
    logic [PART_W-1:0] r_part;
    logic [BLK_W-1:0]  r_blk;

    logic [PART_W-1:0] part_nx;
    logic [BLK_W-1:0]  trk_nx;
    logic [ADDR_W-1:0] addr_nx;

    sag_field_decode #(.REG_W(REG_W)) u_dec (
        .drv_head  (drv_head),
        .cyl_hi    (cyl_hi),
        .cyl_lo    (cyl_lo),
        .sect_num  (sect_num),
        .geo_heads (geo_heads),
        .geo_spt   (geo_spt),
        .blk_mode  (d_mode),
        .flat_blk  (d_flat),
        .cyl       (d_cyl),
        .head      (d_head),
        .bad_req   (d_bad)
    );

    // Stage 1: cylinder * heads + head
    sag_muladd #(.AW(CYL_W), .BW(REG_W), .CW(HEAD_W), .YW(PART_W)) u_mul1 (
        .a (r_cyl), .b (r_heads), .c (r_head), .y (part_nx)
    );

    // Stage 2: partial * sectors-per-track + sector (one is subtracted below)
    sag_muladd #(.AW(PART_W), .BW(REG_W), .CW(REG_W), .YW(BLK_W)) u_mul2 (
        .a (r_part), .b (r_spt), .c (r_sect), .y (trk_nx)
    );

    // Stage 3: block * sector size, modulo 2^ADDR_W
    sag_muladd #(.AW(BLK_W), .BW(SZ_W), .CW(1), .YW(ADDR_W)) u_mul3 (
        .a (r_blk), .b (r_size), .c (1'b0), .y (addr_nx)
    );

    // Start acceptance and default sector size substitution
    assign accept   = (st == ST_IDLE) && start;
    assign size_eff = (sect_bytes == '0) ? SZ_W'(DEF_SECT) : sect_bytes;
    assign busy     = (st != ST_IDLE);

    // Sequencer, operand capture and pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            r_mode  <= 1'b0;
            r_bad   <= 1'b0;
            r_flat  <= '0;
            r_cyl   <= '0;
            r_head  <= '0;
            r_heads <= '0;
            r_spt   <= '0;
            r_sect  <= '0;
            r_size  <= SZ_W'(DEF_SECT);
            r_part  <= '0;
            r_blk   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        r_mode  <= d_mode;
                        r_bad   <= d_bad;
                        r_flat  <= d_flat;
                        r_cyl   <= d_cyl;
                        r_head  <= d_head;
                        r_heads <= geo_heads;
                        r_spt   <= geo_spt;
                        r_sect  <= sect_num;
                        r_size  <= size_eff;
                        st      <= ST_MUL1;
                    end
                end
                ST_MUL1: begin
                    r_part <= part_nx;
                    st     <= ST_MUL2;
                end
                ST_MUL2: begin
                    r_blk <= r_mode ? BLK_W'(r_flat) : (trk_nx - BLK_W'(1));
                    st    <= ST_MUL3;
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Result, status and sector-advance registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            valid     <= 1'b0;
            err       <= 1'b0;
            byte_addr <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                valid <= 1'b0;
                err   <= 1'b0;
            end else if (st == ST_MUL3) begin
                done <= 1'b1;
                if (r_bad) begin
                    err       <= 1'b1;
                    valid     <= 1'b0;
                    byte_addr <= '0;
                end else begin
                    valid     <= 1'b1;
                    byte_addr <= addr_nx;
                end
            end else if ((st == ST_IDLE) && advance && valid) begin
                byte_addr <= byte_addr + ADDR_W'(r_size);
            end
        end
    end
endmodule

// File: rtl/sag_checker.sv
// Module: port-level temporal checks for sector_addr_gen, attached by
// bind. Assumes synchronous active-low reset.
module sag_checker #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              advance,
    input logic              busy,
    input logic              done,
    input logic              valid,
    input logic              err,
    input logic [ADDR_W-1:0] byte_addr
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !valid && !err && byte_addr == '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_err_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!valid && byte_addr == '0));

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !(advance && valid)) |=> $stable(byte_addr));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !valid && !err && !done));

    p_busy_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!valid && !done));
endmodule

bind sector_addr_gen sag_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (advance),
    .busy      (busy),
    .done      (done),
    .valid     (valid),
    .err       (err),
    .byte_addr (byte_addr)
);

// File: tb/sector_addr_gen_tb.sv
module sector_addr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SZ_W   = 14;
    localparam int ADDR_W = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic advance = 1'b0;
    logic [7:0] drv_head = '0, cyl_hi = '0, cyl_lo = '0, sect_num = '0;
    logic [7:0] geo_heads = '0, geo_spt = '0;
    logic [SZ_W-1:0] sect_bytes = '0;
    logic busy, done, valid, err;
    logic [ADDR_W-1:0] byte_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_addr_gen u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .advance (advance),
        .drv_head (drv_head), .cyl_hi (cyl_hi), .cyl_lo (cyl_lo),
        .sect_num (sect_num), .geo_heads (geo_heads), .geo_spt (geo_spt),
        .sect_bytes (sect_bytes), .busy (busy), .done (done),
        .valid (valid), .err (err), .byte_addr (byte_addr)
    );

    // Expected result straight from the requirements (R2..R7, R11)
    function automatic void calc(input logic [7:0] dh, ch, cl, sn, hd, sp,
                                 input logic [SZ_W-1:0] sz,
                                 output bit e, output logic [ADDR_W-1:0] a);
        longint unsigned blk, size, cyl;
        size = (sz == 0) ? 64'd512 : 64'(sz);
        e = 1'b0;
        cyl = {ch, cl};
        if (dh[6]) blk = 64'({dh[3:0], ch, cl, sn});
        else begin
            if (hd == 0 || sp == 0 || sn == 0) e = 1'b1;
            blk = (cyl * 64'(hd) + 64'(dh[3:0])) * 64'(sp) + 64'(sn) - 64'd1;
        end
        a = e ? '0 : ADDR_W'(blk * size);
    endfunction

    // Cycle-by-cycle behavioural reference
    int m_cnt = 0;
    bit m_done = 0, m_valid = 0, m_err = 0, p_err = 0;
    logic [ADDR_W-1:0] m_addr = '0, p_addr = '0;
    longint unsigned m_size = 512;

    always @(posedge clk) begin
        n_cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_valid = 0; m_err = 0; m_addr = '0;
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_err = p_err; m_valid = !p_err; m_addr = p_addr;
                end
            end else if (start) begin
                calc(drv_head, cyl_hi, cyl_lo, sect_num, geo_heads, geo_spt,
                     sect_bytes, p_err, p_addr);
                m_size = (sect_bytes == 0) ? 64'd512 : 64'(sect_bytes);
                m_cnt = 3; m_valid = 0; m_err = 0;
            end else if (advance && m_valid) begin
                m_addr = ADDR_W'(64'(m_addr) + m_size);
            end
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference (R8, R10 timing)
    always @(negedge clk) begin
        if (n_cyc > 0) begin
            chk({busy, done, valid, err, byte_addr} ==
                {m_cnt != 0, m_done, m_valid, m_err, m_addr},
                "R8 R10 per-cycle model",
                64'({busy, done, valid, err, byte_addr}),
                64'({m_cnt != 0, m_done, m_valid, m_err, m_addr}));
        end
    end

    task automatic op(input logic [7:0] dh, ch, cl, sn, hd, sp,
                      input logic [SZ_W-1:0] sz, input bit hold, input string tag);
        bit e;
        logic [ADDR_W-1:0] a;
        calc(dh, ch, cl, sn, hd, sp, sz, e, a);
        @(negedge clk);
        drv_head = dh; cyl_hi = ch; cyl_lo = cl; sect_num = sn;
        geo_heads = hd; geo_spt = sp; sect_bytes = sz;
        start = 1'b1; advance = hold;
        @(negedge clk);
        if (hold) begin
            // R10: restart with other operands while busy must be ignored
            drv_head = ~dh; sect_num = sn + 8'd3; sect_bytes = sz + 1'b1;
        end else start = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        chk(done == 1'b0, "R8 no early done", 64'(done), 64'd0);
        @(negedge clk);
        chk({done, valid, err, byte_addr} == {1'b1, !e, e, a}, tag,
            64'({done, valid, err, byte_addr}), 64'({1'b1, !e, e, a}));
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic adv(input logic [ADDR_W-1:0] exp, input string tag);
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        chk(byte_addr == exp, tag, 64'(byte_addr), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] base;
        repeat (3) @(negedge clk);
        chk({busy, done, valid, err, byte_addr} == '0, "R1 reset state",
            64'({busy, done, valid, err, byte_addr}), 64'd0);
        rst_n = 1'b1;

        // R2 R5 R11: block mode, default size, zero geometry ignored
        op(8'h45, 8'h12, 8'h34, 8'h56, 8'd0, 8'd0, 14'd0, 1'b0, "R2 R5 R11 block mode");
        // R2 R4: largest block number
        op(8'hEF, 8'hFF, 8'hFF, 8'hFF, 8'd4, 8'd9, 14'd512, 1'b0, "R2 R4 max block");
        // R4: odd sector size
        op(8'h40, 8'h00, 8'h01, 8'h03, 8'd1, 8'd1, 14'd520, 1'b0, "R4 odd size");
        // R3: cylinder/head/sector conversion, then R9 advances
        op(8'hA3, 8'h01, 8'h02, 8'd10, 8'd16, 8'd63, 14'd512, 1'b0, "R3 chs convert");
        base = ADDR_W'(((64'd258 * 16 + 3) * 63 + 9) * 512);
        adv(base + 40'd512,  "R9 advance one");
        adv(base + 40'd1024, "R9 advance two");
        // R3: first sector of the disk
        op(8'h00, 8'h00, 8'h00, 8'd1, 8'd2, 8'd17, 14'd256, 1'b0, "R3 first sector");
        adv(40'd256, "R9 advance small size");
        // R6 R7: rejected requests, advance ignored afterwards
        op(8'h01, 8'h00, 8'h05, 8'd1, 8'd0, 8'd63, 14'd0, 1'b0, "R6 zero heads");
        op(8'h01, 8'h00, 8'h05, 8'd1, 8'd4, 8'd0,  14'd0, 1'b0, "R6 zero spt");
        op(8'h01, 8'h00, 8'h05, 8'd0, 8'd4, 8'd63, 14'd0, 1'b0, "R7 sector zero");
        adv(40'd0, "R9 advance ignored when not valid");
        // R4: large geometry with truncation to 40 bits
        op(8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'd255, 8'd255, 14'd16383, 1'b0, "R4 wrap");
        // R10: start/advance held while busy
        op(8'hB2, 8'h00, 8'h07, 8'd5, 8'd8, 8'd32, 14'd1024, 1'b1, "R10 ignore while busy");
        adv(ADDR_W'(((64'd7 * 8 + 2) * 32 + 4) * 1024 + 1024), "R9 advance after busy test");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule